// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular window of in-flight instructions. Each instruction takes a slot at issue time, and the slot number serves as the rename tag. Execution units later post their results into the slot named by that tag. Instructions retire strictly from the oldest end: a register operation updates the architectural register file, a store is sent out as a memory write request, and a branch is simply dropped. If the retiring branch turns out to have been mispredicted, every younger slot is discarded.

Issue logic asks the block for a slot. It can read a finished result by tag before that result retires. A small mapping table, also inside the block, tells issue logic which slot will produce each architectural register. That table is emptied when a misprediction flush happens. Execution units, the branch predictor and the cache are outside the block.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset the buffer is empty (`empty_o`=1), `alloc_ready_o`=1, `alloc_tag_o`=0, and `reg_we_o`, `st_valid_o` and `flush_o` are 0.
- R2: Each accepted allocation returns the tail index on `alloc_tag_o`. Successive accepted allocations return consecutive indices modulo DEPTH. The index does not change unless an allocation is accepted or a flush occurs.
- R3: The kind encoding is 2'b00 for a register operation, 2'b01 for a store and 2'b10 for a branch. The destination field holds the register number (low bits) or the store address.
- R4: A completion writes its value into the tagged slot and marks the slot ready. From the next cycle, a lookup of that tag reports ready with that value, even before retirement. A slot that has not completed reports not ready.
- R5: Retirement happens only when the oldest slot is ready, and it follows allocation order whatever the completion order. A retiring register operation pulses `reg_we_o` with the register and value in the cycle after the retire edge. A retiring store pulses `st_valid_o` with the address and data in the same way.
- R6: At most one slot retires per cycle. A register write and a store request never appear in the same cycle.
- R7: When all DEPTH slots are occupied and the oldest is not ready, `alloc_ready_o` is 0 and an allocation request has no effect.
- R8: When the buffer is full and the oldest slot retires in a cycle, an allocation in that same cycle is accepted into the freed slot. The new entry and the retiring entry do not disturb each other.
- R9: A correctly predicted branch retires without any register write, store request or flush.
- R10: When a branch completed as mispredicted reaches the oldest slot and retires, `flush_o` pulses for one cycle. All younger slots are discarded, the buffer becomes empty, and the next allocation tag is the index after the branch.
- R11: The rename lookup reports, for an architectural register, whether a pending slot will write it and the youngest such slot's tag. The entry is cleared when that slot retires, or on a flush.
- R12: A completion addressed to a slot that holds no entry is ignored. A later allocation into that slot starts not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_kind_i | input | 2 | Kind of the instruction being allocated |
| alloc_dest_i | input | AW | Destination register or store address |
| alloc_ready_o | output | 1 | A slot can be taken this cycle |
| alloc_tag_o | output | IW | Slot index an accepted allocation receives |
| cmp_valid_i | input | 1 | Completion write strobe |
| cmp_tag_i | input | IW | Slot being completed |
| cmp_value_i | input | DW | Result value or store data |
| cmp_mispredict_i | input | 1 | Branch outcome was mispredicted |
| look_tag_i | input | IW | Operand lookup tag |
| look_ready_o | output | 1 | Looked-up slot holds a finished result |
| look_value_o | output | DW | Looked-up result value |
| ren_reg_i | input | RW | Architectural register for rename lookup |
| ren_busy_o | output | 1 | A pending slot will write that register |
| ren_tag_o | output | IW | Tag of the youngest pending writer |
| reg_we_o | output | 1 | Register file write pulse |
| reg_idx_o | output | RW | Register being written |
| reg_data_o | output | DW | Value being written |
| st_valid_o | output | 1 | Store write request pulse |
| st_addr_o | output | AW | Store address |
| st_data_o | output | DW | Store data |
| flush_o | output | 1 | Misprediction flush pulse |
| empty_o | output | 1 | No slot occupied |

## Verification
Results are completed in an order different from issue order, and the oldest one is completed last. This separates in-order retirement from retirement in completion order. The buffer is filled to capacity, and then the oldest slot is completed while a new allocation is presented in the same cycle. This shows whether the freed slot is reused without corrupting the entry that follows it. Branches are retired both correctly and incorrectly predicted, with younger registers and stores already complete behind them; the mispredicted case must drop those results and leave the rename table empty. A stray completion into an empty slot, and two pending writers of the same register, cover the ignore rule and the youngest-wins rename rule.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'b00,
    K_STORE  = 2'b01,
    K_BRANCH = 2'b10
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head and tail pointers carrying an extra wrap bit.
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic          full,
  output logic          empty
);
  logic [IW:0] head_q, tail_q, head_n;

  always_comb head_n = head_q + (IW+1)'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= flush ? head_n : tail_q + (IW+1)'(push);
    end
  end

  assign head_idx = head_q[IW-1:0];
  assign tail_idx = tail_q[IW-1:0];
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[IW-1:0] == tail_q[IW-1:0]) && (head_q[IW] != tail_q[IW]);
endmodule

// File: rtl/rob_store.sv
// Slot storage: RAM-style payload arrays plus flag vectors that can be reset.
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          alloc_we,
  input  logic [IW-1:0] alloc_idx,
  input  rob_kind_e     alloc_kind,
  input  logic [AW-1:0] alloc_dest,
  input  logic          cmp_we,
  input  logic [IW-1:0] cmp_idx,
  input  logic [DW-1:0] cmp_val,
  input  logic          cmp_misp,
  input  logic          pop,
  input  logic [IW-1:0] head_idx,
  output logic          head_rdy,
  output rob_kind_e     head_kind,
  output logic [AW-1:0] head_dest,
  output logic [DW-1:0] head_val,
  output logic          head_misp,
  input  logic [IW-1:0] look_idx,
  output logic          look_rdy,
  output logic [DW-1:0] look_val
);
  rob_kind_e         kind_mem [DEPTH];
  logic [AW-1:0]     dest_mem [DEPTH];
  logic [DW-1:0]     val_mem  [DEPTH];
  logic [DEPTH-1:0]  vld_q, rdy_q, misp_q;

  // Payload arrays: write-enabled only, no reset, so they map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (alloc_we) begin
      kind_mem[alloc_idx] <= alloc_kind;
      dest_mem[alloc_idx] <= alloc_dest;
    end
    if (cmp_we && vld_q[cmp_idx])
      val_mem[cmp_idx] <= cmp_val;
  end

  // Flags. Order of updates: completion, then retire, then allocation (last wins).
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      misp_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cmp_we && cmp_idx == IW'(i) && vld_q[i]) begin
          rdy_q[i]  <= 1'b1;
          misp_q[i] <= cmp_misp;
        end
        if (pop && head_idx == IW'(i)) begin
          vld_q[i] <= 1'b0;
          rdy_q[i] <= 1'b0;
        end
        if (alloc_we && alloc_idx == IW'(i)) begin
          vld_q[i]  <= 1'b1;
          rdy_q[i]  <= 1'b0;
          misp_q[i] <= 1'b0;
        end
      end
    end
  end

  assign head_rdy  = vld_q[head_idx] & rdy_q[head_idx];
  assign head_kind = kind_mem[head_idx];
  assign head_dest = dest_mem[head_idx];
  assign head_val  = val_mem[head_idx];
  assign head_misp = misp_q[head_idx];
  assign look_rdy  = vld_q[look_idx] & rdy_q[look_idx];
  assign look_val  = val_mem[look_idx];
endmodule

// File: rtl/rob_rename.sv
// Architectural register -> pending slot map.
module rob_rename #(
  parameter int NREG  = 16,
  parameter int DEPTH = 8,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          set_we,
  input  logic [RW-1:0] set_reg,
  input  logic [IW-1:0] set_tag,
  input  logic          clr_we,
  input  logic [RW-1:0] clr_reg,
  input  logic [IW-1:0] clr_tag,
  input  logic [RW-1:0] q_reg,
  output logic          q_busy,
  output logic [IW-1:0] q_tag
);
  logic [NREG-1:0] map_vld;
  logic [IW-1:0]   map_tag [NREG];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      map_vld <= '0;
    end else begin
      // Clear only if the retiring slot is still the youngest writer.
      if (clr_we && map_vld[clr_reg] && map_tag[clr_reg] == clr_tag)
        map_vld[clr_reg] <= 1'b0;
      if (set_we)
        map_vld[set_reg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_we) map_tag[set_reg] <= set_tag;
  end

  assign q_busy = map_vld[q_reg];
  assign q_tag  = map_tag[q_reg];
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 16,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid_i,
  input  logic [1:0]    alloc_kind_i,
  input  logic [AW-1:0] alloc_dest_i,
  output logic          alloc_ready_o,
  output logic [IW-1:0] alloc_tag_o,
  input  logic          cmp_valid_i,
  input  logic [IW-1:0] cmp_tag_i,
  input  logic [DW-1:0] cmp_value_i,
  input  logic          cmp_mispredict_i,
  input  logic [IW-1:0] look_tag_i,
  output logic          look_ready_o,
  output logic [DW-1:0] look_value_o,
  input  logic [RW-1:0] ren_reg_i,
  output logic          ren_busy_o,
  output logic [IW-1:0] ren_tag_o,
  output logic          reg_we_o,
  output logic [RW-1:0] reg_idx_o,
  output logic [DW-1:0] reg_data_o,
  output logic          st_valid_o,
  output logic [AW-1:0] st_addr_o,
  output logic [DW-1:0] st_data_o,
  output logic          flush_o,
  output logic          empty_o
);
  logic [IW-1:0] head_idx, tail_idx;
  logic          full, empty;
  logic          head_rdy, head_misp;
  rob_kind_e     head_kind, new_kind;
  logic [AW-1:0] head_dest;
  logic [DW-1:0] head_val;
  logic          retire, mispredict, push;

  assign new_kind   = rob_kind_e'(alloc_kind_i);
  assign retire     = !empty && head_rdy;
  assign mispredict = retire && head_kind == K_BRANCH && head_misp;
  // A full buffer may accept into the slot freed by this cycle's retire,
  // but nothing is accepted in a flush cycle.
  assign alloc_ready_o = (!full || retire) && !mispredict;
  assign push          = alloc_valid_i && alloc_ready_o;
  assign alloc_tag_o   = tail_idx;
  assign empty_o       = empty;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(retire), .flush(mispredict),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty)
  );

  rob_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .flush(mispredict),
    .alloc_we(push), .alloc_idx(tail_idx), .alloc_kind(new_kind), .alloc_dest(alloc_dest_i),
    .cmp_we(cmp_valid_i), .cmp_idx(cmp_tag_i), .cmp_val(cmp_value_i), .cmp_misp(cmp_mispredict_i),
    .pop(retire), .head_idx(head_idx),
    .head_rdy(head_rdy), .head_kind(head_kind), .head_dest(head_dest),
    .head_val(head_val), .head_misp(head_misp),
    .look_idx(look_tag_i), .look_rdy(look_ready_o), .look_val(look_value_o)
  );

  rob_rename #(.NREG(NREG), .DEPTH(DEPTH)) u_ren (
    .clk(clk), .rst(rst), .flush(mispredict),
    .set_we(push && new_kind == K_REG), .set_reg(alloc_dest_i[RW-1:0]), .set_tag(tail_idx),
    .clr_we(retire && head_kind == K_REG), .clr_reg(head_dest[RW-1:0]), .clr_tag(head_idx),
    .q_reg(ren_reg_i), .q_busy(ren_busy_o), .q_tag(ren_tag_o)
  );

  // Registered retire interface.
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we_o   <= 1'b0;
      st_valid_o <= 1'b0;
      flush_o    <= 1'b0;
      reg_idx_o  <= '0;
      reg_data_o <= '0;
      st_addr_o  <= '0;
      st_data_o  <= '0;
    end else begin
      reg_we_o   <= retire && head_kind == K_REG;
      st_valid_o <= retire && head_kind == K_STORE;
      flush_o    <= mispredict;
      if (retire) begin
        reg_idx_o  <= head_dest[RW-1:0];
        reg_data_o <= head_val;
        st_addr_o  <= head_dest;
        st_data_o  <= head_val;
      end
    end
  end
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_valid_i,
  input logic          alloc_ready_o,
  input logic [IW-1:0] alloc_tag_o,
  input logic          reg_we_o,
  input logic          st_valid_o,
  input logic          flush_o,
  input logic          empty_o,
  input logic          ren_busy_o
);
  // R2
  a_r2_tag_holds: assert property (@(posedge clk) disable iff (rst)
    !(alloc_valid_i && alloc_ready_o) |=> ($stable(alloc_tag_o) || flush_o));
  // R6
  a_r6_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_we_o, st_valid_o, flush_o}));
  // R5
  a_r5_retire_from_nonempty: assert property (@(posedge clk) disable iff (rst)
    (reg_we_o || st_valid_o) |-> $past(!empty_o));
  // R10
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> empty_o);
  // R11
  a_r11_flush_clears_map: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> !ren_busy_o);
endmodule

bind rob_core rob_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst(rst), .alloc_valid_i(alloc_valid_i), .alloc_ready_o(alloc_ready_o),
  .alloc_tag_o(alloc_tag_o), .reg_we_o(reg_we_o), .st_valid_o(st_valid_o),
  .flush_o(flush_o), .empty_o(empty_o), .ren_busy_o(ren_busy_o)
);

// File: tb/tb_rob_core.sv
module tb_rob_core;
  localparam int DEPTH = 8, NREG = 16, AW = 16, DW = 32, IW = 3, RW = 4;

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic          alloc_valid_i = 0;
  logic [1:0]    alloc_kind_i = 0;
  logic [AW-1:0] alloc_dest_i = 0;
  logic          alloc_ready_o;
  logic [IW-1:0] alloc_tag_o;
  logic          cmp_valid_i = 0;
  logic [IW-1:0] cmp_tag_i = 0;
  logic [DW-1:0] cmp_value_i = 0;
  logic          cmp_mispredict_i = 0;
  logic [IW-1:0] look_tag_i = 0;
  logic          look_ready_o;
  logic [DW-1:0] look_value_o;
  logic [RW-1:0] ren_reg_i = 0;
  logic          ren_busy_o;
  logic [IW-1:0] ren_tag_o;
  logic          reg_we_o, st_valid_o, flush_o, empty_o;
  logic [RW-1:0] reg_idx_o;
  logic [DW-1:0] reg_data_o, st_data_o;
  logic [AW-1:0] st_addr_o;

  rob_core dut (.*);

  int n_cmp = 0, n_bad = 0;
  logic [IW-1:0] exp_tag = 0;
  logic [49:0] expq[$];
  logic [49:0] got, want;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard pushes: {kind, addr/reg, data}
  task automatic exp_reg(input logic [RW-1:0] r, input logic [DW-1:0] d);
    expq.push_back({2'b00, 16'(r), d});
  endtask
  task automatic exp_st(input logic [AW-1:0] a, input logic [DW-1:0] d);
    expq.push_back({2'b01, a, d});
  endtask
  task automatic exp_flush();
    expq.push_back({2'b10, 16'h0, 32'h0});
  endtask

  task automatic alloc(input string req, input logic [1:0] k, input logic [AW-1:0] d,
                       output logic [IW-1:0] t);
    @(negedge clk);
    alloc_valid_i = 1; alloc_kind_i = k; alloc_dest_i = d;
    #1;
    t = alloc_tag_o;
    chk({req, " alloc tag"}, 64'(t), 64'(exp_tag));
    chk({req, " alloc ready"}, 64'(alloc_ready_o), 64'd1);
    @(posedge clk); #1;
    alloc_valid_i = 0;
    exp_tag = exp_tag + 1'b1;
  endtask

  task automatic complete(input logic [IW-1:0] t, input logic [DW-1:0] v, input logic m);
    @(negedge clk);
    cmp_valid_i = 1; cmp_tag_i = t; cmp_value_i = v; cmp_mispredict_i = m;
    @(posedge clk); #1;
    cmp_valid_i = 0; cmp_mispredict_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every retire event against the scoreboard.
  always @(negedge clk) begin
    if (!rst && (reg_we_o || st_valid_o || flush_o)) begin
      chk("R6 single event per cycle", 64'($countones({reg_we_o, st_valid_o, flush_o})), 64'd1);
      if (reg_we_o)        got = {2'b00, 16'(reg_idx_o), reg_data_o};
      else if (st_valid_o) got = {2'b01, st_addr_o, st_data_o};
      else                 got = {2'b10, 16'h0, 32'h0};
      if (expq.size() == 0) begin
        chk("R5 unexpected retire event", 64'(got), 64'h3_FFFF_FFFF_FFFF);
      end else begin
        want = expq.pop_front();
        chk("R5 retire order/content", 64'(got), 64'(want));
      end
    end
  end

  logic done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] t0, t1, t2, tb, tx, ty, tn;
    logic [IW-1:0] tf [8];

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk("R1 empty", 64'(empty_o), 64'd1);
    chk("R1 ready", 64'(alloc_ready_o), 64'd1);
    chk("R1 tag", 64'(alloc_tag_o), 64'd0);
    chk("R1 outputs idle", 64'({reg_we_o, st_valid_o, flush_o}), 64'd0);

    // R2/R3/R5: out-of-order completion, in-order retire, oldest finishing last
    exp_reg(4'd1, 32'hA); exp_reg(4'd2, 32'hB); exp_st(16'h0040, 32'hC);
    alloc("R2", 2'b00, 16'd1, t0);
    alloc("R2", 2'b00, 16'd2, t1);
    alloc("R3", 2'b01, 16'h0040, t2);
    ren_reg_i = 4'd1; #1;
    chk("R11 busy after alloc", 64'(ren_busy_o), 64'd1);
    chk("R11 tag after alloc", 64'(ren_tag_o), 64'(t0));
    complete(t2, 32'hC, 0);
    complete(t1, 32'hB, 0);
    idle(3);
    // R4 lookup before retire
    look_tag_i = t1; #1;
    chk("R4 lookup ready", 64'(look_ready_o), 64'd1);
    chk("R4 lookup value", 64'(look_value_o), 64'hB);
    look_tag_i = t0; #1;
    chk("R4 unfinished not ready", 64'(look_ready_o), 64'd0);
    chk("R5 nothing retired before oldest", 64'(expq.size()), 64'd3);
    complete(t0, 32'hA, 0);
    idle(5);
    chk("R5 drained", 64'(expq.size()), 64'd0);
    ren_reg_i = 4'd1; #1;
    chk("R11 cleared after retire", 64'(ren_busy_o), 64'd0);

    // R11: two pending writers of the same register
    exp_reg(4'd5, 32'h51);
    alloc("R11", 2'b00, 16'd5, t0);
    alloc("R11", 2'b00, 16'd5, t1);
    ren_reg_i = 4'd5; #1;
    chk("R11 youngest writer tag", 64'(ren_tag_o), 64'(t1));
    complete(t0, 32'h51, 0);
    idle(4);
    chk("R11 still busy after older retires", 64'(ren_busy_o), 64'd1);
    chk("R11 tag kept", 64'(ren_tag_o), 64'(t1));
    exp_reg(4'd5, 32'h52);
    complete(t1, 32'h52, 0);
    idle(4);
    chk("R11 free after youngest retires", 64'(ren_busy_o), 64'd0);

    // R9: correctly predicted branch
    exp_reg(4'd9, 32'h99);
    alloc("R9", 2'b10, 16'd0, tb);
    alloc("R9", 2'b00, 16'd9, tx);
    complete(tx, 32'h99, 0);
    complete(tb, 32'h0, 0);
    idle(4);
    chk("R9 branch retired quietly", 64'({empty_o, 6'(expq.size())}), 64'h40);

    // R7/R8: fill, refuse, retire and allocate in one cycle
    for (int i = 0; i < 8; i++) exp_reg(RW'(i), 32'h100 + i);
    exp_reg(4'd10, 32'h222);
    for (int i = 0; i < 8; i++) alloc("R7", 2'b00, 16'(i), tf[i]);
    @(negedge clk); #1;
    chk("R7 full not ready", 64'(alloc_ready_o), 64'd0);
    alloc_valid_i = 1; alloc_kind_i = 2'b00; alloc_dest_i = 16'd12;
    @(posedge clk); #1; alloc_valid_i = 0;
    chk("R7 refused alloc left tag", 64'(alloc_tag_o), 64'(exp_tag));
    chk("R7 refused alloc left buffer", 64'(empty_o), 64'd0);
    complete(tf[0], 32'h100, 0);
    alloc("R8", 2'b00, 16'd10, tn);
    chk("R8 reused head slot", 64'(tn), 64'(tf[0]));
    for (int i = 1; i < 8; i++) complete(tf[i], 32'h100 + i, 0);
    complete(tn, 32'h222, 0);
    idle(5);
    chk("R8 all retired", 64'({empty_o, 6'(expq.size())}), 64'h40);

    // R10: mispredicted branch discards younger finished work
    exp_reg(4'd3, 32'h33); exp_flush();
    alloc("R10", 2'b00, 16'd3, tx);
    alloc("R10", 2'b10, 16'd0, tb);
    alloc("R10", 2'b00, 16'd6, ty);
    alloc("R10", 2'b01, 16'h0080, t2);
    complete(ty, 32'h66, 0);
    complete(t2, 32'h88, 0);
    complete(tx, 32'h33, 0);
    complete(tb, 32'h0, 1);
    idle(3);
    chk("R10 empty after flush", 64'(empty_o), 64'd1);
    chk("R10 next tag after branch", 64'(alloc_tag_o), 64'(tb + 1'b1));
    ren_reg_i = 4'd6; #1;
    chk("R11 map cleared by flush", 64'(ren_busy_o), 64'd0);
    chk("R10 nothing younger retired", 64'(expq.size()), 64'd0);
    exp_tag = tb + 1'b1;

    // R12: completion into an empty slot is ignored
    complete(exp_tag, 32'hDEAD, 0);
    alloc("R12", 2'b01, 16'h0090, tn);
    look_tag_i = tn; #1;
    chk("R12 stray completion ignored", 64'(look_ready_o), 64'd0);
    idle(3);
    chk("R12 no retire from stray", 64'(empty_o), 64'd0);
    exp_st(16'h0090, 32'h77);
    complete(tn, 32'h77, 0);
    idle(5);
    chk("R12 drained", 64'(expq.size()), 64'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule